// File: doc/BRIEF.md
# Flag-Delimited Serial Frame Receiver with CRC Check

This block takes a serial bit stream that has already been line-decoded and clock-recovered. Each bit arrives with a one-cycle valid strobe. The block recovers bit-stuffed frames that open and close with the 01111110 flag. After enable it hunts for a flag, which fixes byte alignment. It then removes the stuffed zeros and assembles bytes with the first received bit as the MSB. The first byte of each frame is treated as an address and can be used to filter frames.

The assembled bytes pass through a two-byte holding stage. Because of this, the two bytes that come just before the closing flag never reach the receive buffer. Those two bytes are taken as the received CRC and compared with a CRC-CCITT computed over every byte that was forwarded.

The forwarded bytes leave through a push interface to an external receive buffer, with a marker on the final byte of each frame. The buffer reports back through a full input, which drives a DMA request. A push attempted while the buffer is full is dropped and reported as an overrun. A frame aborted by seven or more ones is discarded, and the receiver returns to hunting.

Top module: `flagrx_top`

## Requirements
- R1: While hunting, no byte is pushed. Hunting holds after reset, while `enable` is low, and after an abort, and it ends only when the bit sequence 01111110 is seen. The byte that follows a flag is the address byte. Back-to-back flags are accepted, and each one restarts the wait for an address.
- R2: Bytes are assembled with the first received bit as the MSB. A byte is forwarded only when two later bytes of the same frame have arrived. A forwarded byte is pushed when the next byte is forwarded, or at the closing flag. Pushes leave `pushValid` high for one cycle, one cycle after the clock edge that sampled the completing bit.
- R3: When `addrMatchEn` is 1, a frame is kept only if its address equals `matchAddr` or is 0xFF. When `addrMatchEn` is 0, every frame is kept. The address byte of a kept frame is pushed like any other byte.
- R4: A frame whose address is rejected pushes nothing and raises no CRC error. The receiver waits for the next flag.
- R5: At the closing flag, the last forwarded byte is pushed with `pushLast` = 1. No other push carries `pushLast` = 1.
- R6: The CRC has polynomial 0x1021 (x^16+x^12+x^5+1) and is preset to 0xFFFF for each frame. Each forwarded byte is fed in MSB first. At the closing flag the CRC is compared with the two held bytes, the first held byte being the upper 8 bits. A mismatch gives a one-cycle `crcErrIrq` pulse in the same cycle as the final push.
- R7: A frame with fewer than three bytes between its flags pushes nothing and raises no CRC error.
- R8: Inside a frame, a 0 that follows five consecutive 1s is removed and is not part of any byte. Data holding any bit pattern, including 0x7E and 0xFF, is recovered intact.
- R9: Seven consecutive 1s abort the frame. The byte still waiting to be pushed is dropped, no `pushLast` is given, no CRC error is raised, and the receiver hunts again.
- R10: `dmaReq` equals `bufFull` delayed by one cycle. A push due while `bufFull` is high is not issued. Instead it gives a one-cycle `overrunErr` pulse, and that byte is lost.
- R11: Cycles with `bitValid` low have no effect, whatever value `bitIn` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Receiver enable; low forces hunting and drops any frame in progress |
| addrMatchEn | input | 1 | Enables address filtering |
| matchAddr | input | 8 | Address a frame must carry to be kept (0xFF is always kept) |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| bitIn | input | 1 | Decoded serial data bit |
| bufFull | input | 1 | Receive buffer is full |
| pushValid | output | 1 | Write strobe into the receive buffer |
| pushData | output | 8 | Byte being written |
| pushLast | output | 1 | Written byte ends its frame |
| dmaReq | output | 1 | DMA request, follows `bufFull` |
| overrunErr | output | 1 | Pulse: a push was dropped because the buffer was full |
| crcErrIrq | output | 1 | Pulse: received CRC differs from computed CRC |

## Verification
Every output is registered once behind the bit that triggers it, so each one is due one cycle after its clock edge:
- a push follows the edge that sampled the last bit of the byte three places later in the frame;
- the final push and any CRC error follow the edge that sampled the last 0 of the closing flag;
- `dmaReq` follows `bufFull` by one cycle.

The bench drives inputs on falling edges and records `pushValid`, `crcErrIrq` and `overrunErr` on every falling edge into logs. Each task lets the stream drain for several idle cycles before comparing those logs with byte lists and CRC values it computes itself. Pulses are therefore counted exactly once, wherever they land.

// File: rtl/flagrx_pkg.sv
package flagrx_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } rxState_t;

  // Strobes from bit-level control to the byte datapath
  typedef struct packed {
    logic              keepByte;
    logic [BYTE_W-1:0] byteVal;
    logic              closeFrame;
    logic              dropFrame;
  } rxStrobe_t;

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] crcIn,
                                               input logic [BYTE_W-1:0] dataIn,
                                               input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] c;
    logic fb;
    c = crcIn;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ dataIn[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/flagrx_ctrl.sv
module flagrx_ctrl
  import flagrx_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              addrMatchEn,
  input  logic [BYTE_W-1:0] matchAddr,
  input  logic              bitValid,
  input  logic              bitIn,
  output rxStrobe_t         strobe
);

  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_RUN = STUFF_RUN + 2;
  localparam int CNT_W     = $clog2(ABORT_RUN + 1);
  localparam int BC_W      = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] ONES_STUFF = CNT_W'(STUFF_RUN);
  localparam logic [CNT_W-1:0] ONES_FLAG  = CNT_W'(FLAG_RUN);
  localparam logic [CNT_W-1:0] ONES_MAX   = CNT_W'(ABORT_RUN);
  localparam logic [BC_W-1:0]  BIT_LAST   = BC_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] BCAST     = '1;

  rxState_t          state;
  logic [CNT_W-1:0]  onesCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [BC_W-1:0]   bitCnt;

  logic isOne, isZero, sawAbort, sawFlag, stuffBit, heldOne, shiftEn;
  logic inFrame, byteDone, addrOk;
  logic [BYTE_W-1:0] nextByte;

  always_comb begin
    isOne    = bitValid && bitIn;
    isZero   = bitValid && !bitIn;
    sawAbort = isOne && (onesCnt >= ONES_FLAG);
    sawFlag  = isZero && (onesCnt == ONES_FLAG);
    stuffBit = isZero && (onesCnt == ONES_STUFF);
    heldOne  = isOne && (onesCnt == ONES_STUFF);
    shiftEn  = bitValid && !sawAbort && !sawFlag && !stuffBit && !heldOne;
    nextByte = {shiftReg[BYTE_W-2:0], bitIn};
    inFrame  = (state != ST_HUNT);
    byteDone = enable && inFrame && shiftEn && (bitCnt == BIT_LAST);
    addrOk   = !addrMatchEn || (nextByte == matchAddr) || (nextByte == BCAST);

    strobe.keepByte   = byteDone &&
                        ((state == ST_DATA) || ((state == ST_ADDR) && addrOk));
    strobe.byteVal    = nextByte;
    strobe.closeFrame = enable && sawFlag && (state == ST_DATA);
    strobe.dropFrame  = !enable || sawAbort;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      onesCnt  <= '0;
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      if (bitValid) begin
        if (!bitIn)                 onesCnt <= '0;
        else if (onesCnt != ONES_MAX) onesCnt <= onesCnt + 1'b1;
      end
      if (shiftEn) shiftReg <= nextByte;

      if (!enable || sawAbort || sawFlag) bitCnt <= '0;
      else if (shiftEn)                   bitCnt <= bitCnt + 1'b1;

      if (!enable || sawAbort) state <= ST_HUNT;
      else if (sawFlag)        state <= ST_ADDR;
      else if (byteDone && (state == ST_ADDR))
        state <= addrOk ? ST_DATA : ST_SKIP;
    end
  end

  // R1: nothing is kept while hunting
  p_hunt_silent_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HUNT) |-> !strobe.keepByte);

  // R4: a rejected frame keeps no bytes
  p_skip_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !strobe.keepByte);

  // R8: a stuffed zero never completes a byte
  p_stuff_no_byte_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !bitIn && onesCnt == ONES_STUFF) |-> !strobe.keepByte);

  // R9: a seventh one sends the receiver back to hunting
  p_abort_hunt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && bitValid && bitIn && onesCnt >= ONES_FLAG) |=> (state == ST_HUNT));

  // R11: idle cycles leave the bit state alone
  p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !bitValid && state != ST_HUNT) |=> ($stable(onesCnt) && $stable(bitCnt)));

endmodule

// File: rtl/flagrx_data.sv
module flagrx_data
  import flagrx_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic              bufFull,
  output logic              pushValid,
  output logic [BYTE_W-1:0] pushData,
  output logic              pushLast,
  output logic              dmaReq,
  output logic              overrunErr,
  output logic              crcErrIrq
);

  localparam int HOLD_N = 2;
  localparam int HC_W   = $clog2(HOLD_N + 1);
  localparam logic [HC_W-1:0] HOLD_FULL = HC_W'(HOLD_N);

  logic [BYTE_W-1:0] held [HOLD_N];
  logic [HC_W-1:0]   heldCnt;
  logic [BYTE_W-1:0] pend;
  logic              pendValid;
  logic [CRC_W-1:0]  crcAcc;
  logic [CRC_W-1:0]  rxCrc;

  always_comb rxCrc = {held[0], held[1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldCnt    <= '0;
      pendValid  <= 1'b0;
      pend       <= '0;
      crcAcc     <= CRC_INIT;
      pushValid  <= 1'b0;
      pushData   <= '0;
      pushLast   <= 1'b0;
      dmaReq     <= 1'b0;
      overrunErr <= 1'b0;
      crcErrIrq  <= 1'b0;
      for (int i = 0; i < HOLD_N; i++) held[i] <= '0;
    end else begin
      pushValid  <= 1'b0;
      pushLast   <= 1'b0;
      overrunErr <= 1'b0;
      crcErrIrq  <= 1'b0;
      dmaReq     <= bufFull;

      if (strobe.dropFrame) begin
        heldCnt   <= '0;
        pendValid <= 1'b0;
        crcAcc    <= CRC_INIT;
      end else if (strobe.closeFrame) begin
        if (pendValid) begin
          if (bufFull) overrunErr <= 1'b1;
          else begin
            pushValid <= 1'b1;
            pushData  <= pend;
            pushLast  <= 1'b1;
          end
          if (crcAcc != rxCrc) crcErrIrq <= 1'b1;
        end
        heldCnt   <= '0;
        pendValid <= 1'b0;
        crcAcc    <= CRC_INIT;
      end else if (strobe.keepByte) begin
        if (heldCnt != HOLD_FULL) begin
          held[heldCnt[0]] <= strobe.byteVal;
          heldCnt          <= heldCnt + 1'b1;
        end else begin
          for (int i = 0; i < HOLD_N - 1; i++) held[i] <= held[i+1];
          held[HOLD_N-1] <= strobe.byteVal;
          crcAcc         <= crcByte(crcAcc, held[0], CRC_POLY);
          pend           <= held[0];
          pendValid      <= 1'b1;
          if (pendValid) begin
            if (bufFull) overrunErr <= 1'b1;
            else begin
              pushValid <= 1'b1;
              pushData  <= pend;
            end
          end
        end
      end
    end
  end

  // R2: the holding stage never exceeds two bytes
  p_held_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    heldCnt <= HOLD_FULL);

  // R5: an end marker only travels with a push
  p_last_with_push_r5: assert property (@(posedge clk) disable iff (!rstN)
    pushLast |-> pushValid);

  // R6: CRC errors are only reported at a closing flag
  p_crc_at_close_r6: assert property (@(posedge clk) disable iff (!rstN)
    crcErrIrq |-> $past(strobe.closeFrame));

  // R10: no push is issued into a full buffer
  p_no_push_full_r10: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> !$past(bufFull));

  // R10: DMA request tracks the full flag
  p_dma_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    bufFull |=> dmaReq);

  // R10: a byte is either pushed or reported lost, never both
  p_push_xor_ovr_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(pushValid && overrunErr));

endmodule

// File: rtl/flagrx_top.sv
module flagrx_top
  import flagrx_pkg::*;
#(
  parameter int               STUFF_RUN = 5,
  parameter logic [15:0]      CRC_POLY  = 16'h1021,
  parameter logic [15:0]      CRC_INIT  = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       addrMatchEn,
  input  logic [7:0] matchAddr,
  input  logic       bitValid,
  input  logic       bitIn,
  input  logic       bufFull,
  output logic       pushValid,
  output logic [7:0] pushData,
  output logic       pushLast,
  output logic       dmaReq,
  output logic       overrunErr,
  output logic       crcErrIrq
);

  rxStrobe_t strobe;

  flagrx_ctrl #(
    .STUFF_RUN (STUFF_RUN)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .addrMatchEn (addrMatchEn),
    .matchAddr   (matchAddr),
    .bitValid    (bitValid),
    .bitIn       (bitIn),
    .strobe      (strobe)
  );

  flagrx_data #(
    .CRC_POLY (CRC_POLY),
    .CRC_INIT (CRC_INIT)
  ) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .bufFull    (bufFull),
    .pushValid  (pushValid),
    .pushData   (pushData),
    .pushLast   (pushLast),
    .dmaReq     (dmaReq),
    .overrunErr (overrunErr),
    .crcErrIrq  (crcErrIrq)
  );

endmodule

// File: tb/tb_flagrx_top.sv
module tb_flagrx_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       addrMatchEn = 1'b0;
  logic [7:0] matchAddr = 8'h00;
  logic       bitValid = 1'b0;
  logic       bitIn = 1'b0;
  logic       bufFull = 1'b0;
  logic       pushValid, pushLast, dmaReq, overrunErr, crcErrIrq;
  logic [7:0] pushData;

  always #2.5 clk = ~clk;

  flagrx_top dut (
    .clk(clk), .rstN(rstN), .enable(enable), .addrMatchEn(addrMatchEn),
    .matchAddr(matchAddr), .bitValid(bitValid), .bitIn(bitIn), .bufFull(bufFull),
    .pushValid(pushValid), .pushData(pushData), .pushLast(pushLast),
    .dmaReq(dmaReq), .overrunErr(overrunErr), .crcErrIrq(crcErrIrq)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] pushLog [0:63];
  logic       lastLog [0:63];
  int pushCnt = 0;
  int crcCnt  = 0;
  int ovrCnt  = 0;

  logic [7:0] pay [0:31];
  int payLen = 0;
  int onesRun = 0;
  bit gapMode = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (pushValid && pushCnt < 64) begin
        pushLog[pushCnt] = pushData;
        lastLog[pushCnt] = pushLast;
        pushCnt = pushCnt + 1;
      end
      if (crcErrIrq)  crcCnt = crcCnt + 1;
      if (overrunErr) ovrCnt = ovrCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 7; i >= 0; i--) begin
        logic fb = c[15] ^ pay[k][i];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  task automatic sendBit(input logic b);
    @(negedge clk);
    bitValid = 1'b1;
    bitIn    = b;
    if (gapMode) begin
      @(negedge clk);
      bitValid = 1'b0;
      bitIn    = ~b;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    bitValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic addFlag();
    for (int i = 7; i >= 0; i--) sendBit(i != 7 && i != 0);
    onesRun = 0;
  endtask

  task automatic addByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sendBit(b[i]);
      if (b[i]) onesRun++; else onesRun = 0;
      if (onesRun == 5) begin
        sendBit(1'b0);
        onesRun = 0;
      end
    end
  endtask

  task automatic sendFrame(input bit corrupt);
    logic [15:0] c;
    c = refCrc(payLen);
    if (corrupt) c = c ^ 16'h0100;
    addFlag();
    for (int k = 0; k < payLen; k++) addByte(pay[k]);
    addByte(c[15:8]);
    addByte(c[7:0]);
    addFlag();
    idle(6);
  endtask

  task automatic clearLogs();
    pushCnt = 0; crcCnt = 0; ovrCnt = 0;
  endtask

  task automatic expectFrame(input string req, input int expCrcErr);
    check(pushCnt == payLen, req, pushCnt, payLen);
    for (int i = 0; i < payLen && i < pushCnt; i++) begin
      check(pushLog[i] == pay[i], req, pushLog[i], pay[i]);
      check(lastLog[i] == (i == payLen - 1), {req, " last"}, lastLog[i], (i == payLen - 1));
    end
    check(crcCnt == expCrcErr, {req, " crc"}, crcCnt, expCrcErr);
  endtask

  task automatic setPay5(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                         input logic [7:0] d, input logic [7:0] e);
    pay[0] = a; pay[1] = b; pay[2] = c; pay[3] = d; pay[4] = e; payLen = 5;
  endtask

  task automatic t_reset();
    check(pushValid == 0 && overrunErr == 0 && crcErrIrq == 0 && dmaReq == 0,
          "R1 reset outputs", {pushValid, overrunErr, crcErrIrq, dmaReq}, 0);
  endtask

  task automatic t_hunt();
    clearLogs();
    for (int k = 0; k < 6; k++) addByte(8'hA5);
    idle(4);
    check(pushCnt == 0, "R1 hunt no push", pushCnt, 0);
  endtask

  task automatic t_good();
    clearLogs();
    setPay5(8'h31, 8'h01, 8'h02, 8'h03, 8'h04);
    sendFrame(0);
    expectFrame("R2 R5 R6 good frame", 0);
  endtask

  task automatic t_badCrc();
    clearLogs();
    setPay5(8'h40, 8'hC3, 8'h5A, 8'h99, 8'h10);
    sendFrame(1);
    expectFrame("R6 corrupted crc", 1);
  endtask

  task automatic t_filter();
    addrMatchEn = 1'b1;
    matchAddr   = 8'h31;
    clearLogs();
    setPay5(8'h22, 8'h11, 8'h12, 8'h13, 8'h14);
    sendFrame(1);
    check(pushCnt == 0, "R4 mismatch no push", pushCnt, 0);
    check(crcCnt == 0, "R4 mismatch no crc error", crcCnt, 0);
    clearLogs();
    setPay5(8'hFF, 8'h21, 8'h22, 8'h23, 8'h24);
    sendFrame(0);
    expectFrame("R3 broadcast accepted", 0);
    clearLogs();
    setPay5(8'h31, 8'h61, 8'h62, 8'h63, 8'h64);
    sendFrame(0);
    expectFrame("R3 exact match accepted", 0);
    addrMatchEn = 1'b0;
  endtask

  task automatic t_stuff();
    clearLogs();
    setPay5(8'h7E, 8'hFF, 8'h3F, 8'hF8, 8'h1F);
    sendFrame(0);
    expectFrame("R8 zero deletion", 0);
  endtask

  task automatic t_abort();
    clearLogs();
    addFlag();
    addByte(8'h31); addByte(8'h55); addByte(8'h66); addByte(8'h77);
    for (int i = 0; i < 8; i++) sendBit(1'b1);
    idle(6);
    check(pushCnt == 1, "R9 abort pushes before abort", pushCnt, 1);
    check(pushCnt >= 1 && pushLog[0] == 8'h31 && lastLog[0] == 1'b0,
          "R9 abort no last mark", {pushLog[0], 7'd0, lastLog[0]}, 16'h3100);
    check(crcCnt == 0, "R9 abort no crc error", crcCnt, 0);
    clearLogs();
    setPay5(8'h05, 8'h06, 8'h07, 8'h08, 8'h09);
    sendFrame(0);
    expectFrame("R9 recovery after abort", 0);
  endtask

  task automatic t_short();
    clearLogs();
    addFlag(); addByte(8'h12); addByte(8'h34); addFlag();
    addFlag(); addFlag();
    idle(6);
    check(pushCnt == 0, "R7 short frame no push", pushCnt, 0);
    check(crcCnt == 0, "R7 short frame no crc error", crcCnt, 0);
  endtask

  task automatic t_overrun();
    clearLogs();
    bufFull = 1'b1;
    setPay5(8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5);
    sendFrame(0);
    check(dmaReq == 1'b1, "R10 dma request", dmaReq, 1);
    check(pushCnt == 0, "R10 no push when full", pushCnt, 0);
    check(ovrCnt == 5, "R10 overrun count", ovrCnt, 5);
    bufFull = 1'b0;
    idle(2);
    check(dmaReq == 1'b0, "R10 dma released", dmaReq, 0);
  endtask

  task automatic t_gaps();
    clearLogs();
    gapMode = 1;
    setPay5(8'h5C, 8'h0F, 8'hF0, 8'hFE, 8'h81);
    sendFrame(0);
    gapMode = 0;
    expectFrame("R11 idle cycles ignored", 0);
  endtask

  task automatic t_enable();
    clearLogs();
    addFlag();
    addByte(8'h31); addByte(8'h41); addByte(8'h51); addByte(8'h61);
    @(negedge clk); bitValid = 1'b0; enable = 1'b0;
    @(negedge clk); enable = 1'b1;
    addByte(8'h71); addByte(8'h81);
    addFlag();
    idle(6);
    check(pushCnt == 1, "R1 disable drops frame", pushCnt, 1);
    check(pushCnt >= 1 && lastLog[0] == 1'b0, "R1 disable no last mark", lastLog[0], 0);
    check(crcCnt == 0, "R1 disable no crc error", crcCnt, 0);
    clearLogs();
    setPay5(8'h31, 8'h77, 8'h88, 8'h99, 8'hAA);
    sendFrame(0);
    expectFrame("R1 frame after re-enable", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    t_hunt();
    t_good();
    t_badCrc();
    t_filter();
    t_stuff();
    t_abort();
    t_short();
    t_overrun();
    t_gaps();
    t_enable();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule